// File: doc/BRIEF.md
# Status-Full Packet Discard Tracker

This block sits beside a cell reassembly engine whose completion reports go into a status queue. For every cell it is given, it decides whether the cell is kept or dropped. While the status queue has no room, every cell is dropped. Channels that lose the middle or end of a packet during that time are poisoned. Single-segment, end and OAM cells that arrive while the queue is full ask the queue logic whether room has appeared. When the answer is yes, the full condition ends. After that, each poisoned channel drops its traffic through the next end-of-message cell and then returns to normal.

The queue logic raises `full_set` for one cycle when the last free status entry is used. The block returns its decision one clock after the cell is presented. When a cell triggers a room check, `rechk_req` is raised alongside that decision. The queue logic answers through the level `rechk_room`, which the block samples only while `rechk_req` is high. A global `prot_dis` input turns off every full-related discard.

Top module: `sfd_tracker`

## Requirements
- R1: After a synchronous reset, `dec_vld` and `rechk_req` are low, the full condition is off and every channel is clean, so that the first cell on any channel is accepted.
- R2: `dec_vld` is high exactly one cycle after a cycle with `cell_vld` high. When no cell was presented, `dec_drop` and `rechk_req` are low.
- R3: When the block is not full and the channel is clean, a cell is accepted (`dec_drop` = 0).
- R4: While full and with protection enabled, every cell is dropped, whatever its channel or type. Cell type codes: 0 begin, 1 continuation, 2 end, 3 single-segment, 4 OAM.
- R5: A continuation (1) or end (2) cell dropped while full poisons its channel. A begin (0), single-segment (3) or OAM (4) cell does not poison its channel.
- R6: `rechk_req` rises with the decision for a cell dropped while full whose type is single-segment (3), end (2) or OAM (4), and for no other cell.
- R7: The full condition ends when `rechk_req` and `rechk_room` are both high in the same cycle. A cell presented in that cycle is judged as not full. `rechk_room` has no effect while `rechk_req` is low.
- R8: Once not full, a poisoned channel drops every cell up to and including the next end (2) cell, and then accepts cells again.
- R9: Channels that were not poisoned accept cells as soon as the full condition ends.
- R10: While `prot_dis` is high, every cell is accepted, no room check is requested and no channel state changes.
- R11: `full_set` always puts the block in the full condition for the next cycle, even if an exit happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_vld | input | 1 | A cell is presented this cycle |
| cell_chan | input | CHAN_W | Channel number of the cell |
| cell_type | input | 3 | Cell type code (0 begin, 1 continuation, 2 end, 3 single-segment, 4 OAM) |
| full_set | input | 1 | Pulse: the status queue just became full |
| rechk_room | input | 1 | Room-check answer, sampled while `rechk_req` is high |
| prot_dis | input | 1 | Globally disables full-related discard |
| dec_vld | output | 1 | A decision is presented this cycle |
| dec_drop | output | 1 | 1 = drop the cell, 0 = accept it |
| rechk_req | output | 1 | Request to check the status queue for room |

## Verification
On every cycle, the assertions check the one-cycle decision timing, that a cell is dropped whenever the full condition is in force, that a room request only comes with a dropped cell, that the protection bypass holds, and how the full flag responds to set and exit events. Other behaviour takes a sequence of cells to show, and only the bench's scenarios can reveal it. This covers poisoning by continuation and end cells, the drop run that lasts through the next end cell after recovery, the isolation of clean channels, and a cell arriving in the exit cycle. The bench's reference model tracks the poisoned channels and the full flag in plain variables and compares all three outputs on every clock.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

  typedef enum logic [2:0] {
    CT_BEGIN = 3'd0,
    CT_CONT  = 3'd1,
    CT_END   = 3'd2,
    CT_SINGLE = 3'd3,
    CT_OAM   = 3'd4
  } cell_kind_t;

  typedef enum logic [1:0] {
    CH_CLEAN  = 2'd0,
    CH_MARKED = 2'd1,
    CH_DROP   = 2'd2
  } chan_st_t;

  // cell types that poison their channel when dropped during full
  function automatic logic poisons(input logic [2:0] t);
    return (t == CT_CONT) || (t == CT_END);
  endfunction

  // cell types that ask for a room re-check during full
  function automatic logic probes(input logic [2:0] t);
    return (t == CT_END) || (t == CT_SINGLE) || (t == CT_OAM);
  endfunction

endpackage

// File: rtl/sfd_full_ctrl.sv
module sfd_full_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic full_set,
  input  logic rechk_req,
  input  logic rechk_room,
  output logic full_q,
  output logic full_eff
);

  logic exit_now;

  assign exit_now = full_q && rechk_req && rechk_room;
  assign full_eff = full_q && !exit_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (full_set) begin
      full_q <= 1'b1;
    end else if (exit_now) begin
      full_q <= 1'b0;
    end
  end

  // R7
  full_exit_chk: assert property (@(posedge clk) disable iff (rst)
    full_q && rechk_req && rechk_room && !full_set |=> !full_q);

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    full_q && !(rechk_req && rechk_room) |=> full_q);

  // R11
  full_set_chk: assert property (@(posedge clk) disable iff (rst)
    full_set |=> full_q);

endmodule

// File: rtl/sfd_chan_table.sv
module sfd_chan_table #(
  parameter int NUM_CHAN = 16,
  localparam int CHAN_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAN_W-1:0] rd_idx,
  output sfd_pkg::chan_st_t rd_st,
  input  logic              wr_en,
  input  logic [CHAN_W-1:0] wr_idx,
  input  sfd_pkg::chan_st_t wr_st
);
  import sfd_pkg::*;

  chan_st_t st_mem [NUM_CHAN];

  assign rd_st = st_mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CHAN; i++) begin
        st_mem[i] <= CH_CLEAN;
      end
    end else if (wr_en) begin
      st_mem[wr_idx] <= wr_st;
    end
  end

  // R8
  tbl_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> st_mem[$past(wr_idx)] == $past(wr_st));

endmodule

// File: rtl/sfd_decide.sv
module sfd_decide (
  input  logic              vld,
  input  logic [2:0]        kind,
  input  sfd_pkg::chan_st_t cur_st,
  input  logic              full_eff,
  input  logic              prot_dis,
  output logic              drop,
  output logic              probe,
  output logic              st_we,
  output sfd_pkg::chan_st_t nxt_st
);
  import sfd_pkg::*;

  always_comb begin
    drop   = 1'b0;
    probe  = 1'b0;
    st_we  = 1'b0;
    nxt_st = cur_st;
    if (vld && !prot_dis) begin
      if (full_eff) begin
        drop  = 1'b1;
        probe = probes(kind);
        if (poisons(kind)) begin
          st_we  = 1'b1;
          nxt_st = CH_MARKED;
        end
      end else begin
        unique case (cur_st)
          CH_MARKED: begin
            drop   = 1'b1;
            st_we  = 1'b1;
            nxt_st = (kind == CT_END) ? CH_CLEAN : CH_DROP;
          end
          CH_DROP: begin
            drop = 1'b1;
            if (kind == CT_END) begin
              st_we  = 1'b1;
              nxt_st = CH_CLEAN;
            end
          end
          default: drop = 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/sfd_tracker.sv
module sfd_tracker #(
  parameter int NUM_CHAN = 16,
  localparam int CHAN_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cell_vld,
  input  logic [CHAN_W-1:0] cell_chan,
  input  logic [2:0]        cell_type,
  input  logic              full_set,
  input  logic              rechk_room,
  input  logic              prot_dis,
  output logic              dec_vld,
  output logic              dec_drop,
  output logic              rechk_req
);
  import sfd_pkg::*;

  logic     full_q;
  logic     full_eff;
  chan_st_t cur_st;
  chan_st_t nxt_st;
  logic     drop_c;
  logic     probe_c;
  logic     st_we;

  sfd_full_ctrl u_full (
    .clk       (clk),
    .rst       (rst),
    .full_set  (full_set),
    .rechk_req (rechk_req),
    .rechk_room(rechk_room),
    .full_q    (full_q),
    .full_eff  (full_eff)
  );

  sfd_chan_table #(.NUM_CHAN(NUM_CHAN)) u_tbl (
    .clk   (clk),
    .rst   (rst),
    .rd_idx(cell_chan),
    .rd_st (cur_st),
    .wr_en (st_we),
    .wr_idx(cell_chan),
    .wr_st (nxt_st)
  );

  sfd_decide u_dec (
    .vld     (cell_vld),
    .kind    (cell_type),
    .cur_st  (cur_st),
    .full_eff(full_eff),
    .prot_dis(prot_dis),
    .drop    (drop_c),
    .probe   (probe_c),
    .st_we   (st_we),
    .nxt_st  (nxt_st)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_vld   <= 1'b0;
      dec_drop  <= 1'b0;
      rechk_req <= 1'b0;
    end else begin
      dec_vld   <= cell_vld;
      dec_drop  <= drop_c;
      rechk_req <= probe_c;
    end
  end

  // R2
  dec_follow_chk: assert property (@(posedge clk) disable iff (rst)
    cell_vld |=> dec_vld);

  // R2
  dec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cell_vld |=> !dec_vld && !dec_drop && !rechk_req);

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    cell_vld && full_eff && !prot_dis |=> dec_drop);

  // R3
  clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
    cell_vld && !full_eff && !prot_dis && cur_st == CH_CLEAN |=> !dec_drop);

  // R6
  rechk_drop_chk: assert property (@(posedge clk) disable iff (rst)
    rechk_req |-> dec_vld && dec_drop);

  // R10
  prot_pass_chk: assert property (@(posedge clk) disable iff (rst)
    cell_vld && prot_dis |=> dec_vld && !dec_drop && !rechk_req);

endmodule

// File: tb/sfd_tracker_tb.sv
module sfd_tracker_tb;
  localparam int CLK_P  = 10;
  localparam int NCH    = 16;
  localparam int CW     = $clog2(NCH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cell_vld = 1'b0;
  logic [CW-1:0] cell_chan = '0;
  logic [2:0]    cell_type = 3'd0;
  logic          full_set = 1'b0;
  logic          rechk_room = 1'b0;
  logic          prot_dis = 1'b0;
  logic          dec_vld, dec_drop, rechk_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sfd_tracker #(.NUM_CHAN(NCH)) u_dut (
    .clk(clk), .rst(rst), .cell_vld(cell_vld), .cell_chan(cell_chan),
    .cell_type(cell_type), .full_set(full_set), .rechk_room(rechk_room),
    .prot_dis(prot_dis), .dec_vld(dec_vld), .dec_drop(dec_drop),
    .rechk_req(rechk_req)
  );

  // behavioural reference model
  bit    poison [NCH];
  bit    full_m = 0;
  bit    e_vld = 0, e_drop = 0, e_rq = 0;
  string tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      full_m = 0;
      foreach (poison[i]) poison[i] = 0;
      e_vld = 0; e_drop = 0; e_rq = 0; tag = "R1";
    end else begin
      bit ex, fe, nd, nr;
      ex = full_m && e_rq && rechk_room;
      fe = full_m && !ex;
      nd = 0; nr = 0; tag = "R2";
      if (cell_vld) begin
        if (prot_dis) tag = "R10";
        else if (fe) begin
          nd = 1; tag = "R4";
          if (cell_type == 3'd1 || cell_type == 3'd2) poison[cell_chan] = 1;
          nr = (cell_type == 3'd2 || cell_type == 3'd3 || cell_type == 3'd4);
        end else if (poison[cell_chan]) begin
          nd = 1; tag = "R5 R8";
          if (cell_type == 3'd2) poison[cell_chan] = 0;
        end else tag = ex ? "R7 R9" : "R3";
      end
      if (full_set) full_m = 1;
      else if (ex) full_m = 0;
      e_vld = cell_vld; e_drop = nd; e_rq = nr;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (dec_vld !== e_vld) begin
        errors++;
        $display("FAIL R2 dec_vld act=%0b exp=%0b", dec_vld, e_vld);
      end else if (dec_drop !== e_drop) begin
        errors++;
        $display("FAIL %s dec_drop act=%0b exp=%0b", tag, dec_drop, e_drop);
      end else if (rechk_req !== e_rq) begin
        errors++;
        $display("FAIL R6 rechk_req act=%0b exp=%0b", rechk_req, e_rq);
      end
    end
  end

  task automatic want(input logic act, input logic exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", t, act, exp);
    end
  endtask

  // presents one cell; returns at the negedge where its decision is visible
  task automatic put(input int ch, input int ty, input bit fs = 0);
    cell_vld = 1; cell_chan = CW'(ch); cell_type = 3'(ty); full_set = fs;
    @(negedge clk);
    cell_vld = 0; full_set = 0;
  endtask

  task automatic set_full();
    full_set = 1;
    @(negedge clk);
    full_set = 0;
  endtask

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    want(dec_vld, 1'b0, "R1 dec_vld");
    want(rechk_req, 1'b0, "R1 rechk_req");
    put(3, 0); want(dec_drop, 1'b0, "R1 R3 clean accept");
    put(3, 1); want(dec_drop, 1'b0, "R3");
    put(3, 2); want(dec_drop, 1'b0, "R3");

    set_full();
    put(5, 1); want(dec_drop, 1'b1, "R4 cont"); want(rechk_req, 1'b0, "R6 cont no probe");
    put(6, 0); want(dec_drop, 1'b1, "R4 begin");
    rechk_room = 0;
    put(7, 3); want(dec_drop, 1'b1, "R4 single"); want(rechk_req, 1'b1, "R6 single probe");
    put(8, 0); want(dec_drop, 1'b1, "R7 no room stays full");
    rechk_room = 1;
    put(9, 0); want(dec_drop, 1'b1, "R7 room ignored without req");
    put(9, 4); want(rechk_req, 1'b1, "R6 oam probe");
    put(10, 0); want(dec_drop, 1'b0, "R7 exit cycle cell accepted");
    put(5, 0); want(dec_drop, 1'b1, "R5 R8 poisoned begin");
    put(5, 1); want(dec_drop, 1'b1, "R8 cont");
    put(5, 2); want(dec_drop, 1'b1, "R8 end dropped");
    put(5, 0); want(dec_drop, 1'b0, "R8 recovered");
    put(6, 1); want(dec_drop, 1'b0, "R5 R9 begin did not poison");
    put(7, 0); want(dec_drop, 1'b0, "R9");

    rechk_room = 0;
    set_full();
    put(11, 2); want(rechk_req, 1'b1, "R6 end probe");
    rechk_room = 1;
    put(12, 3);
    put(11, 2); want(dec_drop, 1'b1, "R8 first end after exit");
    put(11, 0); want(dec_drop, 1'b0, "R8 cleared");

    set_full();
    prot_dis = 1;
    put(2, 1); want(dec_drop, 1'b0, "R10 accept"); want(rechk_req, 1'b0, "R10 no probe");
    put(2, 3); want(rechk_req, 1'b0, "R10 no probe single");
    prot_dis = 0;
    put(2, 0); want(dec_drop, 1'b1, "R4 after bypass");
    put(2, 3);
    put(1, 0); want(dec_drop, 1'b0, "R7 exit");
    put(2, 0); want(dec_drop, 1'b0, "R10 no poison");

    set_full();
    put(4, 3);
    put(4, 0, 1); want(dec_drop, 1'b0, "R7 R11 exit cycle");
    put(4, 0); want(dec_drop, 1'b1, "R11 set wins");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      cell_vld   = ($urandom % 10) < 7;
      cell_chan  = CW'($urandom % NCH);
      cell_type  = 3'($urandom % 5);
      full_set   = ($urandom % 40) == 0;
      rechk_room = ($urandom % 5) < 2;
      prot_dis   = ($urandom % 60) == 0;
      @(negedge clk);
    end
    cell_vld = 0; full_set = 0; prot_dis = 0;
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule